// File: doc/BRIEF.md
# Dual-Mode Framebuffer Scan-Out Fetcher

This block feeds pixels to a display pipeline from one of two frame buffers. One is a one-bit-per-pixel monochrome image held in on-chip block RAM and read one 32-bit word at a time. The other is a color image in external memory, read one 128-bit word at a time, at either 8 or 16 bits per pixel. A control bit picks the source at run time. Each buffer has its own relocatable base address. The timing generator supplies an active-video strobe and a one-cycle vertical sync pulse. The block keeps a few fetched words buffered ahead of the beam, so pixels come out with a fixed one-cycle delay.

Software writes the mono base, the color base and a two-bit control field through a small write port. These writes land in shadow registers. The copies that the fetcher actually uses are loaded only on the vertical sync pulse, so a frame never mixes two configurations. Addressing is linear with no row padding, and the 24-bit address covers a 1440x900 image in mono or in 8 bpp color.

Top module: `fbScanout`

## Requirements
- R1: Control field bit 0 selects the source: 0 reads only through the mono port (monoRdEn), 1 reads only through the color port (colorRdReq). The two read strobes are never high together.
- R2: In mono mode each 32-bit word gives 32 pixels, bit 0 first. The pixel sits in pixData[0], and pixData[15:1] is zero.
- R3: In color mode with control bit 1 at 0 (8 bpp), each 128-bit word gives 16 pixels, byte [7:0] first. The index sits in pixData[7:0], and pixData[15:8] is zero.
- R4: In color mode with control bit 1 at 1 (16 bpp), each 128-bit word gives 8 pixels, halfword [15:0] first. Each pixel appears on pixData as 5-6-5 RGB: red in [15:11], green in [10:5], blue in [4:0].
- R5: The color base ignores written bits [3:0], so every color read address is a multiple of 16 and consecutive color reads step by 16.
- R6: The mono base is a 24-bit register that leaves reset at MONO_BASE_DEFAULT. Written bits [1:0] are forced to zero, and consecutive mono reads step by 4.
- R7: On frameStart the fetch address returns to the selected base. It then advances linearly across all lines of the frame.
- R8: Config writes (cfgAddr 0 = mono base, 1 = color base, 2 = control) change nothing until the next frameStart pulse.
- R9: pixValid equals activeVideo delayed by one cycle, and pixData is zero whenever pixValid is low.
- R10: Reads are issued ahead, up to DEPTH words, so no pixel is late when return latency is a few cycles and a short blanking interval follows frameStart.
- R11: Color read data requested before a frameStart pulse and returned after it is discarded.
- R12: During reset pixValid and pixData are zero, and the active mode is mono.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Config write strobe |
| cfgAddr | input | 2 | Config select: 0 mono base, 1 color base, 2 control |
| cfgWrData | input | AW | Config write data |
| frameStart | input | 1 | One-cycle vertical sync pulse |
| activeVideo | input | 1 | High on each active pixel cycle |
| monoRdEn | output | 1 | Block RAM read strobe, data returns next cycle |
| monoRdAddr | output | AW | Block RAM byte address |
| monoRdData | input | 32 | Block RAM read data |
| colorRdReq | output | 1 | External memory read request |
| colorRdAddr | output | AW | External memory byte address |
| colorRdValid | input | 1 | Read data valid, returned in request order |
| colorRdData | input | 128 | External read data |
| pixValid | output | 1 | Pixel valid |
| pixData | output | 16 | Pixel value |

## Verification
Each of the three pixel formats is driven through frames of several lines with blanking between them, and a behavioural model is compared on every clock. This separates errors in lane order, pixel width and word boundaries from errors in address stepping. Config writes made in the middle of a frame show whether the shadow registers are copied across too early. Two sync pulses a few cycles apart leave color reads in flight and expose any stale word that slips into the new frame. A final mono frame with an unaligned relocated base tests both the forced low bits and the switch back from color mode.

// File: rtl/fbPkg.sv
package fbPkg;
  typedef enum logic [1:0] {
    FMT_MONO  = 2'd0,
    FMT_IDX8  = 2'd1,
    FMT_RGB16 = 2'd2
  } pixFmtE;

  localparam logic [1:0] CFG_MONO_BASE  = 2'd0;
  localparam logic [1:0] CFG_COLOR_BASE = 2'd1;
  localparam logic [1:0] CFG_CONTROL    = 2'd2;

  localparam int WORD_W = 128;

  typedef struct packed {
    logic restart;    // frame boundary: reload address, flush buffer
    logic issue;      // a read goes out this cycle
    logic push;       // a returned word enters the buffer
    logic pushColor;  // returned word comes from the color port
  } fetchStrobesT;
endpackage

// File: rtl/fbCtrl.sv
module fbCtrl
  import fbPkg::*;
#(
  parameter int AW = 24,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter logic [AW-1:0] MONO_BASE_DEFAULT = 24'h0E_7F00
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgAddr,
  input  logic [AW-1:0] cfgWrData,
  input  logic          frameStart,
  input  logic          colorRdValid,
  input  logic [CNT_W-1:0] fifoCount,
  output fetchStrobesT  strobes,
  output pixFmtE        activeFmt,
  output logic [AW-1:0] loadBase
);
  localparam int PEND_W = $clog2(DEPTH) + 3;
  localparam int SUM_W  = PEND_W + 1;

  logic [AW-1:0] shMonoBase, shColorBase;
  logic [1:0]    shCtrl;
  pixFmtE        shFmt;
  logic          monoInFlight;
  logic [PEND_W-1:0] colorPending, dropCnt;
  logic [SUM_W-1:0]  inUse;
  logic issue, issueColor, dropHit;

  always_comb begin
    if (!shCtrl[0])     shFmt = FMT_MONO;
    else if (shCtrl[1]) shFmt = FMT_RGB16;
    else                shFmt = FMT_IDX8;
  end

  assign loadBase = (shFmt == FMT_MONO) ? shMonoBase : shColorBase;

  // shadow registers written by software
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shMonoBase  <= {MONO_BASE_DEFAULT[AW-1:2], 2'b00};
      shColorBase <= '0;
      shCtrl      <= 2'b00;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        CFG_MONO_BASE:  shMonoBase  <= {cfgWrData[AW-1:2], 2'b00};
        CFG_COLOR_BASE: shColorBase <= {cfgWrData[AW-1:4], 4'b0000};
        CFG_CONTROL:    shCtrl      <= cfgWrData[1:0];
        default: ;
      endcase
    end
  end

  // active copy switches only at a frame boundary
  always_ff @(posedge clk) begin
    if (!rstN)           activeFmt <= FMT_MONO;
    else if (frameStart) activeFmt <= shFmt;
  end

  assign inUse = SUM_W'(fifoCount) + SUM_W'(monoInFlight)
               + SUM_W'(colorPending) - SUM_W'(dropCnt);
  assign issue      = !frameStart && (inUse < SUM_W'(DEPTH));
  assign issueColor = issue && (activeFmt != FMT_MONO);
  assign dropHit    = colorRdValid && (dropCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      monoInFlight <= 1'b0;
      colorPending <= '0;
      dropCnt      <= '0;
    end else begin
      monoInFlight <= issue && (activeFmt == FMT_MONO);
      colorPending <= colorPending + PEND_W'(issueColor) - PEND_W'(colorRdValid);
      if (frameStart) dropCnt <= colorPending - PEND_W'(colorRdValid);
      else            dropCnt <= dropCnt - PEND_W'(dropHit);
    end
  end

  always_comb begin
    strobes.restart   = frameStart;
    strobes.issue     = issue;
    strobes.push      = !frameStart && (monoInFlight || (colorRdValid && !dropHit));
    strobes.pushColor = !monoInFlight;
  end
endmodule

// File: rtl/fbDatapath.sv
module fbDatapath
  import fbPkg::*;
#(
  parameter int AW = 24,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter logic [AW-1:0] MONO_BASE_DEFAULT = 24'h0E_7F00
) (
  input  logic          clk,
  input  logic          rstN,
  input  fetchStrobesT  strobes,
  input  pixFmtE        activeFmt,
  input  logic [AW-1:0] loadBase,
  input  logic [31:0]   monoRdData,
  input  logic [WORD_W-1:0] colorRdData,
  input  logic          activeVideo,
  output logic [AW-1:0] fetchAddr,
  output logic [CNT_W-1:0] fifoCount,
  output logic          pixValid,
  output logic [15:0]   pixData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [WORD_W-1:0] pushWord, curWord, src, shifted;
  logic [4:0]        pixLeft, perWordM1;
  logic [15:0]       pixNext;
  logic              pop, have;

  assign pushWord = strobes.pushColor ? colorRdData : {{(WORD_W-32){1'b0}}, monoRdData};

  // linear fetch address
  always_ff @(posedge clk) begin
    if (!rstN)                fetchAddr <= {MONO_BASE_DEFAULT[AW-1:2], 2'b00};
    else if (strobes.restart) fetchAddr <= loadBase;
    else if (strobes.issue)   fetchAddr <= fetchAddr + ((activeFmt == FMT_MONO) ? AW'(4) : AW'(16));
  end

  // word buffer
  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.restart) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (strobes.push) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop)          rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      fifoCount <= fifoCount + CNT_W'(strobes.push) - CNT_W'(pop);
    end
  end

  // unpacker
  assign pop  = activeVideo && (pixLeft == '0) && (fifoCount != '0);
  assign have = activeVideo && ((pixLeft != '0) || (fifoCount != '0));
  assign src  = pop ? mem[rdPtr] : curWord;

  always_comb begin
    case (activeFmt)
      FMT_IDX8: begin
        pixNext   = {8'h00, src[7:0]};
        shifted   = src >> 8;
        perWordM1 = 5'd15;
      end
      FMT_RGB16: begin
        pixNext   = src[15:0];
        shifted   = src >> 16;
        perWordM1 = 5'd7;
      end
      default: begin
        pixNext   = {15'h0000, src[0]};
        shifted   = src >> 1;
        perWordM1 = 5'd31;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixLeft  <= '0;
      curWord  <= '0;
      pixValid <= 1'b0;
      pixData  <= '0;
    end else begin
      pixValid <= activeVideo;
      pixData  <= have ? pixNext : 16'h0000;
      if (have) begin
        curWord <= shifted;
        pixLeft <= pop ? perWordM1 : pixLeft - 1'b1;
      end
      if (strobes.restart) pixLeft <= '0;
    end
  end
endmodule

// File: rtl/fbScanout.sv
module fbScanout
  import fbPkg::*;
#(
  parameter int AW = 24,
  parameter int DEPTH = 4,
  parameter logic [AW-1:0] MONO_BASE_DEFAULT = 24'h0E_7F00
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgAddr,
  input  logic [AW-1:0] cfgWrData,
  input  logic          frameStart,
  input  logic          activeVideo,
  output logic          monoRdEn,
  output logic [AW-1:0] monoRdAddr,
  input  logic [31:0]   monoRdData,
  output logic          colorRdReq,
  output logic [AW-1:0] colorRdAddr,
  input  logic          colorRdValid,
  input  logic [127:0]  colorRdData,
  output logic          pixValid,
  output logic [15:0]   pixData
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fetchStrobesT     strobes;
  pixFmtE           activeFmt;
  logic [AW-1:0]    loadBase, fetchAddr;
  logic [CNT_W-1:0] fifoCount;

  fbCtrl #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W), .MONO_BASE_DEFAULT(MONO_BASE_DEFAULT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .frameStart(frameStart), .colorRdValid(colorRdValid), .fifoCount(fifoCount),
    .strobes(strobes), .activeFmt(activeFmt), .loadBase(loadBase)
  );

  fbDatapath #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W), .MONO_BASE_DEFAULT(MONO_BASE_DEFAULT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .activeFmt(activeFmt), .loadBase(loadBase),
    .monoRdData(monoRdData), .colorRdData(colorRdData), .activeVideo(activeVideo),
    .fetchAddr(fetchAddr), .fifoCount(fifoCount), .pixValid(pixValid), .pixData(pixData)
  );

  assign monoRdEn    = strobes.issue && (activeFmt == FMT_MONO);
  assign colorRdReq  = strobes.issue && (activeFmt != FMT_MONO);
  assign monoRdAddr  = fetchAddr;
  assign colorRdAddr = fetchAddr;
endmodule

// File: rtl/fbScanoutChecker.sv
module fbScanoutChecker #(
  parameter int AW = 24,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          frameStart,
  input logic          activeVideo,
  input logic          monoRdEn,
  input logic [AW-1:0] monoRdAddr,
  input logic          colorRdReq,
  input logic [AW-1:0] colorRdAddr,
  input logic          pixValid,
  input logic [15:0]   pixData,
  input logic [1:0]    activeFmt,
  input logic [CNT_W-1:0] fifoCount
);
  a_r1_one_source: assert property (@(posedge clk) disable iff (!rstN)
    !(monoRdEn && colorRdReq));
  a_r1_mono_port_in_mono: assert property (@(posedge clk) disable iff (!rstN)
    monoRdEn |-> (activeFmt == 2'd0));
  a_r1_color_port_in_color: assert property (@(posedge clk) disable iff (!rstN)
    colorRdReq |-> (activeFmt != 2'd0));
  a_r5_color_aligned: assert property (@(posedge clk) disable iff (!rstN)
    colorRdReq |-> (colorRdAddr[3:0] == 4'h0));
  a_r6_mono_aligned: assert property (@(posedge clk) disable iff (!rstN)
    monoRdEn |-> (monoRdAddr[1:0] == 2'b00));
  a_r8_mode_holds: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeFmt));
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    activeVideo |=> pixValid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !activeVideo |=> !pixValid);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> (pixData == 16'h0000));
  a_r10_buffer_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));
endmodule

bind fbScanout fbScanoutChecker #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .activeVideo(activeVideo),
  .monoRdEn(monoRdEn), .monoRdAddr(monoRdAddr), .colorRdReq(colorRdReq),
  .colorRdAddr(colorRdAddr), .pixValid(pixValid), .pixData(pixData),
  .activeFmt(activeFmt), .fifoCount(fifoCount)
);

// File: tb/fbScanout_bench.sv
module fbScanout_bench;
  localparam int AW = 24;
  localparam logic [23:0] DEF_BASE = 24'h0E_7F00;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rstN;
  logic cfgWrEn;
  logic [1:0] cfgAddr;
  logic [AW-1:0] cfgWrData;
  logic frameStart, activeVideo;
  logic monoRdEn, colorRdReq, colorRdValid, pixValid;
  logic [AW-1:0] monoRdAddr, colorRdAddr;
  logic [31:0] monoRdData;
  logic [127:0] colorRdData;
  logic [15:0] pixData;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curTag = "R12";

  always #10 clk = ~clk;

  fbScanout u_fbScanout (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .frameStart(frameStart), .activeVideo(activeVideo),
    .monoRdEn(monoRdEn), .monoRdAddr(monoRdAddr), .monoRdData(monoRdData),
    .colorRdReq(colorRdReq), .colorRdAddr(colorRdAddr), .colorRdValid(colorRdValid),
    .colorRdData(colorRdData), .pixValid(pixValid), .pixData(pixData)
  );

  function automatic logic [31:0] memWord(input logic [23:0] a);
    logic [31:0] x;
    x = {8'h00, a} * 32'h9E37_79B1;
    return x ^ 32'h5A5A_1234 ^ {a[7:0], 24'h0};
  endfunction

  function automatic logic [127:0] colorWord(input logic [23:0] a);
    return {memWord(a + 24'd12), memWord(a + 24'd8), memWord(a + 24'd4), memWord(a)};
  endfunction

  // memory models: block RAM one cycle, external memory LAT cycles in order
  logic [LAT-1:0] pipeV;
  logic [23:0] pipeA [LAT];
  always @(posedge clk) begin
    if (monoRdEn) monoRdData <= memWord(monoRdAddr);
    for (int i = LAT - 1; i > 0; i--) begin
      pipeV[i] <= pipeV[i-1];
      pipeA[i] <= pipeA[i-1];
    end
    pipeV[0] <= colorRdReq && rstN;
    pipeA[0] <= colorRdAddr;
  end
  assign colorRdValid = pipeV[LAT-1];
  assign colorRdData  = colorWord(pipeA[LAT-1]);

  // reference model: shadow and frame copies of config, pixel index, read address
  logic [23:0] shM, shC, frM, frC, nextAddr;
  logic [1:0] shCtl, frCtl;
  int p;
  logic expValid;
  logic [15:0] expData;

  function automatic logic [15:0] refPix(input int idx);
    logic [127:0] w;
    if (!frCtl[0]) begin
      w = {96'h0, memWord(frM + 24'(idx / 32) * 24'd4)};
      return {15'h0, w[idx % 32]};
    end else if (!frCtl[1]) begin
      w = colorWord(frC + 24'(idx / 16) * 24'd16);
      return {8'h00, w[(idx % 16) * 8 +: 8]};
    end else begin
      w = colorWord(frC + 24'(idx / 8) * 24'd16);
      return w[(idx % 8) * 16 +: 16];
    end
  endfunction

  initial pipeV = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      shM = DEF_BASE; shC = 24'h0; shCtl = 2'b00;
      frM = DEF_BASE; frC = 24'h0; frCtl = 2'b00;
      nextAddr = DEF_BASE; p = 0; expValid = 1'b0; expData = 16'h0;
    end else begin
      // R1 R5 R6 R7: read port and address stepping
      if (monoRdEn || colorRdReq) begin
        checks++;
        if (monoRdEn && colorRdReq) begin
          errors++; $display("FAIL R1 both ports act=1 exp=0");
        end else if (monoRdEn != !frCtl[0]) begin
          errors++; $display("FAIL R1 mono=%0b exp=%0b", monoRdEn, !frCtl[0]);
        end else if ((monoRdEn ? monoRdAddr : colorRdAddr) != nextAddr) begin
          errors++; $display("FAIL R5 R6 R7 addr act=%h exp=%h",
                             monoRdEn ? monoRdAddr : colorRdAddr, nextAddr);
        end
        nextAddr = nextAddr + (frCtl[0] ? 24'd16 : 24'd4);
      end
      if (frameStart) begin
        frM = shM; frC = shC; frCtl = shCtl; p = 0;
        nextAddr = shCtl[0] ? shC : shM;
      end
      if (cfgWrEn) begin
        case (cfgAddr)
          2'd0: shM = {cfgWrData[23:2], 2'b00};
          2'd1: shC = {cfgWrData[23:4], 4'h0};
          2'd2: shCtl = cfgWrData[1:0];
          default: ;
        endcase
      end
      expValid = activeVideo;
      expData  = activeVideo ? refPix(p) : 16'h0;
      if (activeVideo) p++;
    end
  end

  // per-clock comparison, R9 R10 plus the current frame's tags
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (pixValid !== expValid || pixData !== expData) begin
        errors++;
        $display("FAIL R9 R10 %s pix act v=%0b d=%h exp v=%0b d=%h",
                 curTag, pixValid, pixData, expValid, expData);
      end
    end
  end

  task automatic cyc(input bit av);
    @(negedge clk);
    activeVideo = av; frameStart = 1'b0; cfgWrEn = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    activeVideo = 1'b0; frameStart = 1'b0;
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
  endtask

  task automatic vsync();
    @(negedge clk);
    activeVideo = 1'b0; cfgWrEn = 1'b0; frameStart = 1'b1;
  endtask

  task automatic lines(input int n, input int len);
    for (int l = 0; l < n; l++) begin
      for (int i = 0; i < len; i++) cyc(1'b1);
      for (int i = 0; i < 8; i++) cyc(1'b0);
    end
  endtask

  task automatic frame(input int n);
    vsync();
    for (int i = 0; i < 16; i++) cyc(1'b0);
    lines(n, 48);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgAddr = 2'd0; cfgWrData = '0;
    frameStart = 1'b0; activeVideo = 1'b0;
    repeat (5) @(negedge clk);
    checks++; // R12 reset outputs
    if (pixValid !== 1'b0 || pixData !== 16'h0) begin
      errors++; $display("FAIL R12 reset act v=%0b d=%h exp v=0 d=0000", pixValid, pixData);
    end
    rstN = 1'b1;
    cyc(1'b0);

    curTag = "R2 R6 R7 R12"; // default mono base
    frame(3);
    wr(2'd2, 24'h000001);     // color, 8 bpp
    wr(2'd1, 24'h200009);     // low bits dropped
    curTag = "R8";            // still mono until sync
    lines(1, 48);

    curTag = "R3 R5 R1";
    frame(3);
    wr(2'd2, 24'h000003);     // color, 16 bpp
    wr(2'd1, 24'h3100F7);
    curTag = "R8";
    lines(1, 40);

    curTag = "R4 R11";        // second sync while reads are in flight
    vsync();
    cyc(1'b0); cyc(1'b0);
    frame(3);

    wr(2'd0, 24'h012347);     // relocated mono base, low bits dropped
    wr(2'd2, 24'h000000);
    curTag = "R8";
    lines(1, 48);
    curTag = "R1 R2 R6";
    frame(3);
    for (int i = 0; i < 4; i++) cyc(1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule